// File: doc/BRIEF.md
# Two-Thread Shared Fetch Cache

This block is a small instruction-fetch cache that two hardware threads share through one lookup port. Each thread keeps its own fetch pointer. In every clock cycle an arbiter picks at most one thread to look up its pointer in a direct-mapped array of lines. A hit returns the word, tagged with the winning thread, and moves that thread's pointer on by one word. A miss sends a request to the next memory level, and that thread sits out arbitration until the line comes back.

Each line records the thread that filled it. A lookup hits only when the line is valid, its address tag matches, and its owner is the requesting thread. Capacity is not split between the threads, so one thread may hold most or all of the lines. A redirect input per thread loads a new fetch pointer. If that thread has a miss in flight when the redirect arrives, the returning line is dropped and not installed.

Top module: `smt_fetch_cache`

## Requirements
- R1: After synchronous reset, `hit_vld_o` and `miss_vld_o` are 0, both fetch pointers are 0, and every line is invalid, so the first fetch of each address misses.
- R2: A thread's pointer rises by one only in the cycle after that thread is granted and hits. A redirect loads `redir_pc_i[t]` at the next edge, and the thread is not granted in the cycle its redirect is high. Otherwise the pointer holds.
- R3: When both threads are eligible in consecutive cycles, the grants alternate. Priority passes to the other thread after every granted access.
- R4: A thread is eligible only when its request is high, its stall is low, and it has no miss outstanding. A lone eligible thread is granted in every cycle, so it can hit once per cycle.
- R5: A lookup hits only on a valid line whose address tag and owner thread ID both match. One cycle after a granted hit, `hit_vld_o` pulses with the thread ID, the pointer used, and the line data.
- R6: One cycle after a granted miss, `miss_vld_o` pulses with the missing address and thread ID. That thread stays ineligible until `fill_vld_i` with its ID arrives, and the fill installs the line as owned by that thread.
- R7: Lines are not split between threads. One thread can own more than half of the 16 lines and still hit on all of them.
- R8: If a thread is redirected while its miss is outstanding, the fill that returns for it is discarded: the line at that index keeps its old contents. The thread's outstanding state still clears, so the thread can fetch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Per-thread fetch request |
| stall_i | input | 2 | Per-thread stall; a stalled thread is not granted |
| redir_i | input | 2 | Per-thread redirect strobe |
| redir_pc_i | input | 2x12 | Per-thread new fetch pointer (word address) |
| fill_vld_i | input | 1 | A line returns from the next level |
| fill_tid_i | input | 1 | Thread the returning line belongs to |
| fill_data_i | input | 32 | Returning line data |
| miss_vld_o | output | 1 | Miss request pulse to the next level |
| miss_tid_o | output | 1 | Thread of the miss request |
| miss_addr_o | output | 12 | Word address of the miss |
| hit_vld_o | output | 1 | Hit result valid |
| hit_tid_o | output | 1 | Thread of the hit |
| hit_pc_o | output | 12 | Fetch pointer that hit |
| hit_data_o | output | 32 | Hit data |
| pc_o | output | 2x12 | Current fetch pointer of each thread |

## Verification
The assertions assume that a fill arrives only for a thread that has a miss outstanding, and at most one fill per cycle. They also assume the next level answers each miss exactly once. The bench's responder answers each miss pulse with exactly one fill in the following cycle. In the discard test the responder is held off and the bench drives a single fill by hand, only after the redirect, so no fill ever arrives for a thread that is not waiting on one.

// File: rtl/fcache_pkg.sv
package fcache_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LINES  = 16;
    localparam int NTHR   = 2;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef struct packed {
        logic  vld;
        logic  owner;
        tag_t  tag;
        data_t data;
    } line_t;

    function automatic idx_t idx_of(addr_t a);
        return a[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/fcache_arb.sv
module fcache_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] elig,
    output logic       gnt_vld,
    output logic       gnt_id
);
    logic prio_q;

    always_comb begin
        gnt_vld = |elig;
        if (elig == 2'b11) gnt_id = prio_q;
        else               gnt_id = elig[1];
    end

    always_ff @(posedge clk) begin
        if (rst)          prio_q <= 1'b0;
        else if (gnt_vld) prio_q <= ~gnt_id;
    end

    AST_RR_FLIP: assert property (@(posedge clk) disable iff (rst)
        (gnt_vld && elig == 2'b11) |=> (elig != 2'b11 || gnt_id != $past(gnt_id))); // R3
endmodule

// File: rtl/fcache_thread.sv
module fcache_thread import fcache_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  redir,
    input  addr_t redir_pc,
    input  logic  adv,
    input  logic  miss,
    input  logic  fill_mine,
    output addr_t pc,
    output addr_t pend_addr,
    output logic  pend,
    output logic  discard
);
    logic drop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            pend      <= 1'b0;
            drop_q    <= 1'b0;
            pend_addr <= '0;
        end else begin
            if (redir)    pc <= redir_pc;
            else if (adv) pc <= pc + 1'b1;
            if (miss) begin
                pend      <= 1'b1;
                pend_addr <= pc;
            end else if (fill_mine) begin
                pend      <= 1'b0;
            end
            if (fill_mine)          drop_q <= 1'b0;
            else if (redir && pend) drop_q <= 1'b1;
        end
    end

    assign discard = drop_q | redir;

    AST_PC_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!adv && !redir) |=> $stable(pc)); // R2
    AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fill_mine |=> !pend); // R8
    AST_MISS_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        miss |-> !pend); // R6
endmodule

// File: rtl/fcache_tags.sv
module fcache_tags import fcache_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  addr_t look_addr,
    input  logic  look_tid,
    output logic  look_hit,
    output data_t look_data,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  logic  wr_tid,
    input  data_t wr_data
);
    line_t lines_q [LINES];
    line_t sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) lines_q[i].vld <= 1'b0;
        end else if (wr_en) begin
            lines_q[idx_of(wr_addr)] <= '{vld: 1'b1, owner: wr_tid,
                                          tag: tag_of(wr_addr), data: wr_data};
        end
    end

    always_comb begin
        sel       = lines_q[idx_of(look_addr)];
        look_hit  = sel.vld && (sel.owner == look_tid) && (sel.tag == tag_of(look_addr));
        look_data = sel.data;
    end
endmodule

// File: rtl/smt_fetch_cache.sv
module smt_fetch_cache import fcache_pkg::*; (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NTHR-1:0]              req_i,
    input  logic [NTHR-1:0]              stall_i,
    input  logic [NTHR-1:0]              redir_i,
    input  logic [NTHR-1:0][ADDR_W-1:0]  redir_pc_i,
    input  logic                         fill_vld_i,
    input  logic                         fill_tid_i,
    input  logic [DATA_W-1:0]            fill_data_i,
    output logic                         miss_vld_o,
    output logic                         miss_tid_o,
    output logic [ADDR_W-1:0]            miss_addr_o,
    output logic                         hit_vld_o,
    output logic                         hit_tid_o,
    output logic [ADDR_W-1:0]            hit_pc_o,
    output logic [DATA_W-1:0]            hit_data_o,
    output logic [NTHR-1:0][ADDR_W-1:0]  pc_o
);
    addr_t           pc_w   [NTHR];
    addr_t           pa_w   [NTHR];
    logic [NTHR-1:0] pend, discard, elig, adv, miss, fill_mine;
    logic            gnt_vld, gnt_id, tag_hit, hit_now, miss_now, wr_en;
    data_t           look_data;
    addr_t           look_addr;

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        assign elig[g]      = req_i[g] & ~stall_i[g] & ~pend[g] & ~redir_i[g];
        assign adv[g]       = hit_now  & (gnt_id == 1'(g));
        assign miss[g]      = miss_now & (gnt_id == 1'(g));
        assign fill_mine[g] = fill_vld_i & (fill_tid_i == 1'(g)) & pend[g];
        assign pc_o[g]      = pc_w[g];

        fcache_thread u_thr (
            .clk       (clk),
            .rst       (rst),
            .redir     (redir_i[g]),
            .redir_pc  (redir_pc_i[g]),
            .adv       (adv[g]),
            .miss      (miss[g]),
            .fill_mine (fill_mine[g]),
            .pc        (pc_w[g]),
            .pend_addr (pa_w[g]),
            .pend      (pend[g]),
            .discard   (discard[g])
        );
    end

    fcache_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .elig    (elig),
        .gnt_vld (gnt_vld),
        .gnt_id  (gnt_id)
    );

    assign look_addr = pc_w[gnt_id];
    assign hit_now   = gnt_vld & tag_hit;
    assign miss_now  = gnt_vld & ~tag_hit;
    assign wr_en     = fill_vld_i & pend[fill_tid_i] & ~discard[fill_tid_i];

    fcache_tags u_tags (
        .clk       (clk),
        .rst       (rst),
        .look_addr (look_addr),
        .look_tid  (gnt_id),
        .look_hit  (tag_hit),
        .look_data (look_data),
        .wr_en     (wr_en),
        .wr_addr   (pa_w[fill_tid_i]),
        .wr_tid    (fill_tid_i),
        .wr_data   (fill_data_i)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vld_o   <= 1'b0;
            miss_vld_o  <= 1'b0;
            hit_tid_o   <= 1'b0;
            miss_tid_o  <= 1'b0;
            hit_pc_o    <= '0;
            hit_data_o  <= '0;
            miss_addr_o <= '0;
        end else begin
            hit_vld_o  <= hit_now;
            miss_vld_o <= miss_now;
            if (gnt_vld) begin
                hit_tid_o   <= gnt_id;
                miss_tid_o  <= gnt_id;
                hit_pc_o    <= look_addr;
                miss_addr_o <= look_addr;
                hit_data_o  <= look_data;
            end
        end
    end

    AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> (req_i[gnt_id] && !stall_i[gnt_id] && !pend[gnt_id])); // R4
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(hit_vld_o && miss_vld_o)); // R5
    AST_MISS_PENDING: assert property (@(posedge clk) disable iff (rst)
        miss_vld_o |-> pend[miss_tid_o]); // R6
    AST_HIT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        hit_vld_o |-> (pc_o[hit_tid_o] == hit_pc_o + 1'b1)); // R2
endmodule

// File: tb/tb_smt_fetch_cache.sv
module tb_smt_fetch_cache;
    import fcache_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [1:0]                  req_i = '0, stall_i = '0, redir_i = '0;
    logic [1:0][ADDR_W-1:0]      redir_pc_i = '0;
    logic                        fill_vld_i = 1'b0, fill_tid_i = 1'b0;
    logic [DATA_W-1:0]           fill_data_i = '0;
    logic                        miss_vld_o, miss_tid_o, hit_vld_o, hit_tid_o;
    logic [ADDR_W-1:0]           miss_addr_o, hit_pc_o;
    logic [DATA_W-1:0]           hit_data_o;
    logic [1:0][ADDR_W-1:0]      pc_o;

    smt_fetch_cache dut (.*);

    always #4 clk = ~clk;

    int    total = 0, bad = 0;
    addr_t expq0[$], expq1[$];
    addr_t mon_e;
    int    hits_seen[2] = '{0, 0};
    int    miss_seen[2] = '{0, 0};
    bit    in_win = 0, have_last = 0, hold_fill = 0;
    logic  last_tid = 1'b0;
    int    alt_breaks = 0;

    function automatic data_t mem_word(addr_t a);
        return {8'hC3, a, ~a};
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    // monitor / scoreboard and next-level responder
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (hit_vld_o) begin
                hits_seen[hit_tid_o]++;
                if ((hit_tid_o ? expq1.size() : expq0.size()) == 0) begin
                    chk(0, "R5", "unexpected hit pc", hit_pc_o, 0);
                end else begin
                    mon_e = hit_tid_o ? expq1.pop_front() : expq0.pop_front();
                    chk(hit_pc_o == mon_e, "R2", "hit pointer", hit_pc_o, mon_e);
                    chk(hit_data_o == mem_word(mon_e), "R5", "hit data", hit_data_o, mem_word(mon_e));
                end
                if (in_win) begin
                    if (have_last && last_tid == hit_tid_o) alt_breaks++;
                    last_tid  = hit_tid_o;
                    have_last = 1;
                end
            end
            if (miss_vld_o) miss_seen[miss_tid_o]++;
            if (!hold_fill) begin
                fill_vld_i  = miss_vld_o;
                fill_tid_i  = miss_tid_o;
                fill_data_i = mem_word(miss_addr_o);
            end
        end
    end

    task automatic push(int t, addr_t a);
        if (t == 0) expq0.push_back(a); else expq1.push_back(a);
    endtask

    task automatic redirect(int t, addr_t a);
        @(negedge clk); redir_i[t] = 1'b1; redir_pc_i[t] = a;
        @(negedge clk); redir_i[t] = 1'b0;
    endtask

    task automatic pulse(int t);
        @(negedge clk); req_i[t] = 1'b1;
        @(negedge clk); req_i[t] = 1'b0;
    endtask

    task automatic walk(int t, addr_t start, int n);
        int target;
        redirect(t, start);
        for (int k = 0; k < n; k++) push(t, start + addr_t'(k));
        target = hits_seen[t] + n;
        req_i[t] = 1'b1;
        while (hits_seen[t] < target) @(negedge clk);
        req_i[t] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int h0, h1, m0, m1;
        repeat (3) @(negedge clk);
        chk(hit_vld_o == 0, "R1", "hit_vld in reset", hit_vld_o, 0);
        chk(miss_vld_o == 0, "R1", "miss_vld in reset", miss_vld_o, 0);
        chk(pc_o[0] == 0 && pc_o[1] == 0, "R1", "pointers in reset", pc_o, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(pc_o[0] == 0, "R1", "pointer 0 after reset", pc_o[0], 0);

        // cold walk: every first fetch misses, then hits
        walk(0, 0, 8);
        chk(miss_seen[0] == 8, "R1", "thread0 cold misses", miss_seen[0], 8);
        chk(hits_seen[0] == 8, "R6", "thread0 hits after fills", hits_seen[0], 8);
        walk(1, 8, 8);
        chk(miss_seen[1] == 8, "R6", "thread1 cold misses", miss_seen[1], 8);

        // full bandwidth for one thread while the other is stalled
        req_i[1] = 1'b1; stall_i[1] = 1'b1;
        redirect(0, 0);
        for (int k = 0; k < 8; k++) push(0, addr_t'(k));
        h0 = hits_seen[0]; h1 = hits_seen[1]; m0 = miss_seen[0]; m1 = miss_seen[1];
        req_i[0] = 1'b1;
        repeat (8) @(negedge clk);
        req_i[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk(hits_seen[0] - h0 == 8, "R4", "hits in 8 cycles", hits_seen[0] - h0, 8);
        chk(hits_seen[1] == h1, "R4", "stalled thread hits", hits_seen[1] - h1, 0);
        chk(miss_seen[0] + miss_seen[1] == m0 + m1, "R4", "misses in window", miss_seen[0] + miss_seen[1] - m0 - m1, 0);
        chk(pc_o[0] == 8, "R2", "pointer after 8 hits", pc_o[0], 8);
        req_i[1] = 1'b0; stall_i[1] = 1'b0;

        // both threads eligible: alternating grants
        redirect(0, 0);
        redirect(1, 8);
        for (int k = 0; k < 8; k++) begin push(0, addr_t'(k)); push(1, addr_t'(8 + k)); end
        h0 = hits_seen[0]; h1 = hits_seen[1];
        in_win = 1; have_last = 0; alt_breaks = 0;
        req_i = 2'b11;
        repeat (16) @(negedge clk);
        req_i = 2'b00;
        repeat (2) @(negedge clk);
        in_win = 0;
        chk(alt_breaks == 0, "R3", "repeated grants", alt_breaks, 0);
        chk(hits_seen[0] - h0 == 8, "R3", "thread0 share", hits_seen[0] - h0, 8);
        chk(hits_seen[1] - h1 == 8, "R3", "thread1 share", hits_seen[1] - h1, 8);
        chk(pc_o[1] == 16, "R2", "thread1 pointer", pc_o[1], 16);

        // owner tag isolation: line 0 belongs to thread0
        redirect(1, 0);
        pulse(1);
        chk(miss_vld_o == 1 && miss_tid_o == 1, "R5", "foreign line misses", {miss_vld_o, miss_tid_o}, 2'b11);
        chk(miss_addr_o == 0, "R6", "miss address", miss_addr_o, 0);
        chk(hit_vld_o == 0, "R5", "no hit on foreign line", hit_vld_o, 0);
        repeat (3) @(negedge clk);

        // thread1 now owns 9 lines
        m1 = miss_seen[1]; h1 = hits_seen[1];
        push(1, 0);
        pulse(1);
        redirect(1, 8);
        for (int k = 0; k < 8; k++) push(1, addr_t'(8 + k));
        req_i[1] = 1'b1;
        repeat (8) @(negedge clk);
        req_i[1] = 1'b0;
        repeat (2) @(negedge clk);
        chk(hits_seen[1] - h1 == 9, "R7", "thread1 hits on 9 lines", hits_seen[1] - h1, 9);
        chk(miss_seen[1] == m1, "R7", "thread1 misses", miss_seen[1] - m1, 0);

        // redirect while a miss is outstanding discards the fill
        @(negedge clk); hold_fill = 1; fill_vld_i = 1'b0;
        redirect(0, 32);
        pulse(0);
        chk(miss_vld_o == 1 && miss_addr_o == 32, "R6", "miss to 32", miss_addr_o, 32);
        redirect(0, 0);
        chk(pc_o[0] == 0, "R2", "redirect loads pointer", pc_o[0], 0);
        @(negedge clk); fill_vld_i = 1'b1; fill_tid_i = 1'b0; fill_data_i = 32'hDEAD_BEEF;
        @(negedge clk); fill_vld_i = 1'b0; hold_fill = 0;
        redirect(1, 0);
        push(1, 0);
        pulse(1);
        chk(hit_vld_o == 1 && hit_tid_o == 1, "R8", "line 0 kept after discard", {hit_vld_o, hit_tid_o}, 2'b11);
        pulse(0);
        chk(miss_vld_o == 1 && miss_tid_o == 0, "R8", "thread0 fetches again", {miss_vld_o, miss_tid_o}, 2'b10);
        repeat (4) @(negedge clk);
        chk(expq0.size() == 0 && expq1.size() == 0, "R2", "expected hits left", expq0.size() + expq1.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule